// File: doc/BRIEF.md
# Eight-bit multicycle accumulator processor

This block is a compact 8-bit processor. A one-hot timing counter steps it through fetch and execute. Each instruction starts with a fetch. The address register takes the program counter. The counter then advances while the read is in flight, and the opcode is latched. Execute phases follow, and their number depends on the opcode. Ten single-byte opcodes operate on three data registers A, B and R. A and B are loaded by instructions. R is loaded only at reset, from the `r_init` input.

Register-to-register and ALU operations finish in four cycles. Instructions that carry a second byte take longer: the byte is an immediate value (six cycles) or a direct memory address (seven cycles for a store, eight for a load). The program counter always moves past the operand byte. The memory port is synchronous: read data appears one cycle after the address. Any opcode outside the defined set halts the processor until reset.

Top module: `acc8_cpu`

## Requirements
- R1: A synchronous reset clears A, B, the program counter and the halt flag, loads R from `r_init`, and keeps `mem_we` low. The first opcode is fetched from address 0x00.
- R2: Opcodes 0x02 (A+B), 0x03 (A−B), 0x04 (A AND B) and 0x05 (A OR B) write the result, modulo 256, into A. They leave B unchanged, take 4 cycles, and the next opcode is at the following address.
- R3: Opcode 0x06 copies R into A and opcode 0x07 copies R into B. Each takes 4 cycles.
- R4: Opcode 0x08 loads the next byte into A and opcode 0x09 loads the next byte into B. Each takes 6 cycles, and the next opcode is fetched two bytes after the opcode.
- R5: Opcode 0x00 loads A from the memory address held in the next byte. It takes 8 cycles, and the next opcode is two bytes on.
- R6: Opcode 0x01 writes A to the address held in the next byte. `mem_we` is high for exactly one cycle, the 7th and last cycle of the instruction, with `mem_addr` and `mem_wdata` valid in that cycle.
- R7: An opcode above 0x09 sets `halted` in its 4th cycle. From then on `halted` stays high, A and B hold, `mem_addr` stays still and `mem_we` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| r_init | input | 8 | Value loaded into R at reset |
| mem_addr | output | 8 | Memory address (the address register) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| halted | output | 1 | Sticky halt on an undefined opcode |
| dbg_a | output | 8 | Current value of A |
| dbg_b | output | 8 | Current value of B |

## Verification
The timing counter and the program counter are internal, so a fault in either shows at the ports only through its effects. A phase that is dropped or doubled moves the cycle in which A or B changes, or the single write-enable pulse. A comparison made every clock against a model that counts cycles catches this at the first instruction affected. A program counter that does not skip an operand makes the processor run the operand byte as an opcode. A and B then go wrong within a few instructions, or `halted` rises early. A wrong value latched into the instruction register shows the same way, in the cycle where the result is committed.

// File: rtl/acc8_cpu.sv
module acc8_cpu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] r_init,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata,
  output logic         halted,
  output logic [W-1:0] dbg_a,
  output logic [W-1:0] dbg_b
);
  localparam int NPH = 8;
  localparam logic [W-1:0] OP_LDA = W'(0), OP_STA = W'(1), OP_ADD = W'(2),
                           OP_SUB = W'(3), OP_AND = W'(4), OP_OR  = W'(5),
                           OP_MRA = W'(6), OP_MRB = W'(7), OP_LIA = W'(8),
                           OP_LIB = W'(9);

  logic [W-1:0]   mar, mbr, a, b, r, pc, ir, alu;
  logic [NPH-1:0] t;
  logic           halt;

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = t[6] && ir == OP_STA && !halt;
  assign halted    = halt;
  assign dbg_a     = a;
  assign dbg_b     = b;

  always_comb begin
    case (ir)
      OP_ADD:  alu = a + b;
      OP_SUB:  alu = a - b;
      OP_AND:  alu = a & b;
      default: alu = a | b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0; mbr <= '0; a <= '0; b <= '0; r <= r_init;
      pc <= '0; ir <= '0; t <= NPH'(1); halt <= 1'b0;
    end else if (!halt) begin
      t <= t << 1;
      if (t[0]) mar <= pc;
      if (t[1]) pc <= pc + 1'b1;
      if (t[2]) ir <= mem_rdata;
      if (t[3]) begin
        case (ir)
          OP_ADD, OP_SUB, OP_AND, OP_OR: begin a <= alu; t <= NPH'(1); end
          OP_MRA: begin a <= r; t <= NPH'(1); end
          OP_MRB: begin b <= r; t <= NPH'(1); end
          OP_LDA, OP_STA, OP_LIA, OP_LIB: mar <= pc;
          default: begin halt <= 1'b1; t <= t; end
        endcase
      end
      if (t[4]) pc <= pc + 1'b1;
      if (t[5]) begin
        case (ir)
          OP_LIA: begin a <= mem_rdata; t <= NPH'(1); end
          OP_LIB: begin b <= mem_rdata; t <= NPH'(1); end
          default: begin
            mar <= mem_rdata;
            mbr <= (ir == OP_STA) ? a : mem_rdata;
          end
        endcase
      end
      if (t[6] && ir == OP_STA) t <= NPH'(1);
      if (t[7]) begin a <= mem_rdata; t <= NPH'(1); end
    end
  end
endmodule

module acc8_cpu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         mem_we,
  input logic         halted,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] dbg_a,
  input logic [W-1:0] dbg_b
);
  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= rst;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    seen_rst |-> (dbg_a == '0 && dbg_b == '0 && !halted && !mem_we)); // R1
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R7
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(dbg_a) && $stable(dbg_b) && $stable(mem_addr))); // R7
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we); // R7
endmodule

bind acc8_cpu acc8_cpu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .halted(halted),
  .mem_addr(mem_addr), .dbg_a(dbg_a), .dbg_b(dbg_b)
);

// File: tb/acc8_cpu_tb.sv
module acc8_cpu_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] r_init = 8'h15;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, dbg_a, dbg_b;
  logic mem_we, halted;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  acc8_cpu u_dut (.clk(clk), .rst(rst), .r_init(r_init), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .halted(halted), .dbg_a(dbg_a), .dbg_b(dbg_b));

  logic [7:0] mem [256];
  logic [7:0] mm  [256];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // reference model: instruction-level, cycle-counted
  int ph;
  logic [7:0] ma, mb, mpc;
  bit mh;

  function automatic int op_len(input logic [7:0] op);
    case (op)
      8'h00: return 8;
      8'h01: return 7;
      8'h08, 8'h09: return 6;
      default: return 4;
    endcase
  endfunction

  function automatic string op_tag(input logic [7:0] op);
    case (op)
      8'h00: return "R5";
      8'h01: return "R6";
      8'h02, 8'h03, 8'h04, 8'h05: return "R2";
      8'h06, 8'h07: return "R3";
      8'h08, 8'h09: return "R4";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; ma = 8'h00; mb = 8'h00; mpc = 8'h00; mh = 1'b0;
    end else if (!mh) begin
      logic [7:0] op, nx;
      op = mm[mpc];
      nx = mm[mpc + 8'd1];
      if (ph == op_len(op) - 1) begin
        case (op)
          8'h00: ma = mm[nx];
          8'h01: mm[nx] = ma;
          8'h02: ma = ma + mb;
          8'h03: ma = ma - mb;
          8'h04: ma = ma & mb;
          8'h05: ma = ma | mb;
          8'h06: ma = r_init;
          8'h07: mb = r_init;
          8'h08: ma = nx;
          8'h09: mb = nx;
          default: mh = 1'b1;
        endcase
        if (!mh) begin
          mpc = mpc + ((op <= 8'h01 || op >= 8'h08) ? 8'd2 : 8'd1);
          ph = 0;
        end
      end else ph++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  bit run = 1'b0;
  always @(negedge clk) if (run && !rst) begin
    logic [7:0] op;
    bit ewe;
    op  = mm[mpc];
    ewe = !mh && op == 8'h01 && ph == 6;
    chk(dbg_a == ma, op_tag(op), "A", dbg_a, ma);
    chk(dbg_b == mb, op_tag(op), "B", dbg_b, mb);
    chk(halted == mh, "R7", "halted", halted, mh);
    chk(mem_we == ewe, "R6", "mem_we", mem_we, ewe);
    if (ewe) begin
      chk(mem_addr == mm[mpc + 8'd1], "R6", "store addr", mem_addr, mm[mpc + 8'd1]);
      chk(mem_wdata == ma, "R6", "store data", mem_wdata, ma);
    end
  end

  initial begin
    logic [7:0] prog [30];
    int cyc;
    prog = '{8'h06, 8'h09, 8'h0E, 8'h02, 8'h07, 8'h08, 8'h3F, 8'h03,
             8'h01, 8'h40, 8'h08, 8'h0A, 8'h09, 8'h03, 8'h04, 8'h09,
             8'h09, 8'h05, 8'h00, 8'h40, 8'h03, 8'h09, 8'h30, 8'h03,
             8'h08, 8'hF0, 8'h09, 8'h20, 8'h02, 8'hFF};
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; mm[i] = 8'h00; end
    for (int i = 0; i < 30; i++) begin mem[i] = prog[i]; mm[i] = prog[i]; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(dbg_a == 8'h00, "R1", "reset A", dbg_a, 0);
    chk(dbg_b == 8'h00, "R1", "reset B", dbg_b, 0);
    chk(!halted && !mem_we, "R1", "reset halted/we", {halted, mem_we}, 0);
    run = 1'b1;
    cyc = 0;
    while (!halted && cyc < 2000) begin @(negedge clk); cyc++; end
    if (cyc >= 2000) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual %0d expected halt", cyc);
    end
    repeat (10) @(negedge clk);
    chk(dbg_a == 8'h10, "R2", "final A (wrapped add)", dbg_a, 8'h10);
    chk(dbg_b == 8'h20, "R4", "final B", dbg_b, 8'h20);
    chk(mem[8'h40] == 8'h2A, "R6", "stored byte", mem[8'h40], 8'h2A);
    chk(halted, "R7", "halt sticky", halted, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule